// File: doc/BRIEF.md
# Per-Line Programmable Edge Detector Bank

This block watches a wide vector of independent single-bit signals and reports, line by line, when a chosen kind of transition occurs. Every line carries its own 2-bit edge selection (rising, falling or both directions) and its own gating bit. The selections are packed sixteen to a 32-bit register and the gating bits thirty-two to a register. All of them are reached over a plain register port: word address, write data, write strobe and combinational read data.

Software loads the selection and gating registers, then sets a global run bit. The bank samples the inputs on every clock and compares each sample with the one taken a cycle earlier. It drives a registered one-cycle pulse on a line's event output when that line's selected edge appears. A single summary output is high whenever any per-line pulse is high. Clearing the run bit stops all detection.

Top module: `edge_bank`

## Requirements
- R1: With default parameters the bank has 256 lines. Bit n of `evt` reports only on bit n of `lines_in`, and every line works independently of the others.
- R2: Selection code 0 reports a 0-to-1 change, code 1 reports a 1-to-0 change, and code 2 reports a change in either direction.
- R3: Selection code 3 never produces an event on its line.
- R4: A line can raise its event only while its gating bit is 1. A line whose gating bit is 0 keeps its event low.
- R5: The control register sits at word address 0, with the run bit in bit 0. While the run bit is 0 every event output stays low.
- R6: Reset clears the run bit, every selection field and every gating bit, so all lines select rising edges and are gated off. All outputs read 0 after reset.
- R7: No event is raised for the first clock edge at which the run bit is already 1. Detection starts one clock later.
- R8: Suppose the value of a line at clock edge k differs from its value at edge k-1 in the selected way. Its `evt` bit is then high from edge k to edge k+1, and it falls back if the line holds still.
- R9: Selection registers sit at word addresses 16 to 31. Line n uses register 16+n/16, bits 2*(n mod 16)+1 down to 2*(n mod 16). Gating registers sit at word addresses 32 to 39. Line n uses register 32+n/32, bit n mod 32.
- R10: `evt_any` equals the OR of all `evt` bits in the same cycle.
- R11: Selection and gating registers read back the last value written. The control register reads the run bit in bit 0 and zeros above it. Unmapped addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Write strobe, acts on the rising clock edge |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| lines_in | input | 256 | Monitored signal vector |
| evt | output | 256 | Per-line registered event pulses |
| evt_any | output | 1 | OR of all event pulses |

## Verification
The bench targets the first cycle after the run bit is set. A design that compares against a stale sample would report a spurious burst of edges there. It toggles a reserved-code line and a gated-off line: a design that decodes code 3 as toggle, or ignores the gating array, would pulse on those lines. It checks lines 33, 240 and 255 to catch packing-offset mistakes, which would move a line's behaviour onto a neighbour. It also holds inputs steady after an edge to catch pulses that stick for more than one cycle, and writes an unmapped address to catch aliasing onto a real register.

// File: rtl/edge_bank.sv
`timescale 1ns/1ps
module edge_bank #(
  parameter int NLINES  = 256,
  parameter int DW      = 32,
  parameter int AW      = 6,
  parameter int SEL_BASE  = 16,
  parameter int GATE_BASE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              reg_we,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NLINES-1:0] lines_in,
  output logic [NLINES-1:0] evt,
  output logic              evt_any
);
  localparam int CW   = 2;
  localparam int PER  = DW / CW;
  localparam int NSEL = NLINES / PER;
  localparam int NGT  = NLINES / DW;

  logic              en_q, arm_q;
  logic [DW-1:0]     sel_q [NSEL];
  logic [DW-1:0]     gate_q [NGT];
  logic [NLINES-1:0] samp_q, hit;
  logic [31:0]       a32;

  assign a32 = 32'(reg_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      for (int i = 0; i < NSEL; i++) sel_q[i] <= '0;
      for (int i = 0; i < NGT; i++) gate_q[i] <= '0;
    end else if (reg_we) begin
      if (a32 == 32'd0) en_q <= reg_wdata[0];
      for (int i = 0; i < NSEL; i++)
        if (a32 == 32'(SEL_BASE + i)) sel_q[i] <= reg_wdata;
      for (int i = 0; i < NGT; i++)
        if (a32 == 32'(GATE_BASE + i)) gate_q[i] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (a32 == 32'd0) reg_rdata[0] = en_q;
    for (int i = 0; i < NSEL; i++)
      if (a32 == 32'(SEL_BASE + i)) reg_rdata = sel_q[i];
    for (int i = 0; i < NGT; i++)
      if (a32 == 32'(GATE_BASE + i)) reg_rdata = gate_q[i];
  end

  for (genvar n = 0; n < NLINES; n++) begin : g_line
    localparam int SR = n / PER;
    localparam int SB = CW * (n % PER);
    logic [CW-1:0] code;
    logic          rise, fall;
    assign code = sel_q[SR][SB +: CW];
    assign rise = lines_in[n] & ~samp_q[n];
    assign fall = ~lines_in[n] & samp_q[n];
    assign hit[n] = en_q & arm_q & gate_q[n / DW][n % DW] &
                    ((code == 2'd0 & rise) | (code == 2'd1 & fall) |
                     (code == 2'd2 & (rise | fall)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      arm_q  <= 1'b0;
      evt    <= '0;
    end else begin
      samp_q <= lines_in;
      arm_q  <= en_q;
      evt    <= hit;
    end
  end

  assign evt_any = |evt;
endmodule

module edge_bank_chk #(
  parameter int NLINES = 256,
  parameter int AW     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_q,
  input logic              arm_q,
  input logic              lin0,
  input logic              smp0,
  input logic [1:0]        sel0,
  input logic              gate0,
  input logic [NLINES-1:0] evt_all,
  input logic              reg_we,
  input logic [AW-1:0]     reg_addr,
  input logic              wd0
);
  a_r5_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (evt_all == '0));
  a_r7_first_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |=> (evt_all == '0));
  a_r4_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gate0 |=> !evt_all[0]);
  a_r3_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (sel0 == 2'd3) |=> !evt_all[0]);
  a_r2_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && arm_q && gate0 && sel0 == 2'd0 && lin0 && !smp0) |=> evt_all[0]);
  a_r2_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && arm_q && gate0 && sel0 == 2'd1 && !lin0 && smp0) |=> evt_all[0]);
  a_r11_run_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == '0) |=> (en_q == $past(wd0)));
endmodule

bind edge_bank edge_bank_chk #(.NLINES(NLINES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .arm_q(arm_q),
  .lin0(lines_in[0]), .smp0(samp_q[0]), .sel0(sel_q[0][1:0]),
  .gate0(gate_q[0][0]), .evt_all(evt), .reg_we(reg_we),
  .reg_addr(reg_addr), .wd0(reg_wdata[0])
);

// File: tb/edge_bank_bench.sv
`timescale 1ns/1ps
module edge_bank_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [5:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic         reg_we = 1'b0;
  logic [31:0]  reg_rdata;
  logic [255:0] lines_in = '0;
  logic [255:0] evt;
  logic         evt_any;

  edge_bank u_edge_bank (.*);

  always #10 clk = ~clk;

  typedef struct { logic [255:0] e; string t; } item_t;
  item_t q[$];

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0]  sh_sel [16];
  logic [31:0]  sh_gate [8];
  logic         m_en = 0, m_arm = 0;
  logic [255:0] m_prev = '0, cur_v = '0;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] model(input logic [255:0] c, input logic [255:0] p);
    logic [255:0] r = '0;
    for (int n = 0; n < 256; n++) begin
      logic [1:0] cd = sh_sel[n/16][2*(n%16) +: 2];
      logic rs = c[n] & ~p[n], fl = ~c[n] & p[n];
      if (sh_gate[n/32][n%32])
        r[n] = (cd == 2'd0 && rs) || (cd == 2'd1 && fl) || (cd == 2'd2 && (rs || fl));
    end
    return r;
  endfunction

  function automatic logic [31:0] sh_read(input logic [5:0] a);
    if (a == 6'd0) return {31'b0, m_en};
    if (a >= 6'd16 && a <= 6'd31) return sh_sel[a - 6'd16];
    if (a >= 6'd32 && a <= 6'd39) return sh_gate[a - 6'd32];
    return 32'h0;
  endfunction

  task automatic cycle(input logic [255:0] v, input logic we, input logic [5:0] a,
                       input logic [31:0] d, input string tag);
    item_t it;
    @(negedge clk);
    lines_in = v; cur_v = v;
    reg_we = we; reg_addr = a; reg_wdata = d;
    it.e = (m_en && m_arm) ? model(v, m_prev) : '0;
    it.t = tag;
    q.push_back(it);
    @(posedge clk);
    m_arm = m_en;
    m_prev = v;
    if (we) begin
      if (a == 6'd0) m_en = d[0];
      else if (a >= 6'd16 && a <= 6'd31) sh_sel[a - 6'd16] = d;
      else if (a >= 6'd32 && a <= 6'd39) sh_gate[a - 6'd32] = d;
    end
    #1 reg_we = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input string tag);
    cycle(cur_v, 1'b1, a, d, tag);
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    cycle(cur_v, 1'b0, a, 32'h0, tag);
    #1 chk(reg_rdata === sh_read(a), tag, 256'(reg_rdata), 256'(sh_read(a)));
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        it = q.pop_front();
        chk(evt === it.e, it.t, evt, it.e);
        chk(evt_any === (|it.e), "R10 any", 256'(evt_any), 256'(|it.e));
      end
    end
  end

  initial begin : watchdog
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 16; i++) sh_sel[i] = '0;
    for (int i = 0; i < 8; i++) sh_gate[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    chk(evt === '0, "R6 reset evt", evt, '0);
    chk(evt_any === 1'b0, "R6 reset any", 256'(evt_any), '0);
    rd(6'd0, "R6 ctrl"); rd(6'd16, "R6 sel0"); rd(6'd31, "R6 sel15");
    rd(6'd32, "R6 gate0"); rd(6'd39, "R6 gate7");

    wr(6'd16, 32'hE4E4E4E4, "R9 cfg");
    wr(6'd18, 32'h00000004, "R9 cfg");
    wr(6'd31, 32'hAAAAAAAA, "R9 cfg");
    wr(6'd32, 32'hFFFFFFEF, "R9 cfg");
    wr(6'd33, 32'h00000002, "R9 cfg");
    wr(6'd39, 32'hFFFF0000, "R9 cfg");
    rd(6'd16, "R11 sel0"); rd(6'd31, "R11 sel15"); rd(6'd32, "R11 gate0");
    wr(6'd63, 32'hFFFFFFFF, "R11 unmapped");
    rd(6'd63, "R11 unmapped read"); rd(6'd16, "R11 sel0 intact"); rd(6'd0, "R11 ctrl intact");

    cycle({256{1'b1}}, 0, 0, 0, "R5 off");
    cycle('0, 0, 0, 0, "R5 off");
    wr(6'd0, 32'h1, "R5 enable");
    cycle({256{1'b1}}, 0, 0, 0, "R7 first");
    cycle('0, 0, 0, 0, "R2 fall toggle");
    cycle(256'h1, 0, 0, 0, "R2 rise");
    cycle(256'h1, 0, 0, 0, "R8 hold");
    cycle(256'h1, 0, 0, 0, "R8 hold");
    cycle(256'h8, 0, 0, 0, "R3 reserved");
    cycle(256'h10, 0, 0, 0, "R4 gated");
    cycle(256'h0, 0, 0, 0, "R4 gated");
    cycle(256'h2 << 32, 0, 0, 0, "R9 line33");
    cycle(256'h0, 0, 0, 0, "R9 line33 fall");
    cycle(256'h1 << 255, 0, 0, 0, "R9 line255");
    cycle(256'h1 << 240, 0, 0, 0, "R9 line240");
    rd(6'd0, "R11 ctrl");
    for (int i = 0; i < 60; i++) cycle(rnd256(), 0, 0, 0, "R1 random");

    wr(6'd0, 32'h0, "R5 disable");
    for (int i = 0; i < 5; i++) cycle(rnd256(), 0, 0, 0, "R5 off random");
    for (int i = 0; i < 16; i++) wr(6'(16 + i), $urandom, "R9 cfg all");
    for (int i = 0; i < 8; i++) wr(6'(32 + i), $urandom | 32'h0F0F0F0F, "R9 cfg all");
    rd(6'd20, "R11 sel4"); rd(6'd37, "R11 gate5");
    wr(6'd0, 32'h1, "R5 enable");
    cycle(rnd256(), 0, 0, 0, "R7 first");
    for (int i = 0; i < 80; i++) cycle(rnd256(), 0, 0, 0, "R1 random");
    for (int i = 0; i < 4; i++) cycle(cur_v, 0, 0, 0, "R8 steady");

    repeat (3) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule